// File: doc/BRIEF.md
# Single-to-Half Precision Narrowing Converter with Stochastic Rounding

This block takes one IEEE binary32 operand per cycle and returns its binary16 equivalent one clock later. The operand is first sorted into one of seven classes. A finite operand that is in range is then realigned so that the bits binary16 can keep stand above a fixed-width discard field. A rounding increment is worked out from that field and added to the packed result. The increment is chosen by a mode input. In nearest mode it follows round to nearest, with ties going to the even neighbour. In stochastic mode a caller-supplied random word is lined up under the discard field and added to it, and the carry out of that add is the increment. Over many operations this gives an unbiased result, which stops small addends from being swamped in long sums.

The seven operand classes are ZERO, TINY, SUBN, NORM, HUGE, INF and NAN. Together they cover every binary32 encoding. There are three classification transitions. A biased input exponent below 101, or a binary32 subnormal, goes to TINY. An exponent from 101 to 112 goes to SUBN. An exponent from 113 to 142 goes to NORM, and anything above that which is still finite goes to HUGE. Two rounding transitions can follow inside the rounded classes. A carry can promote a SUBN result to the smallest normal. A carry can also lift a NORM result from exponent 30 to infinity. The random word is 25 bits wide with the default frame. Its most significant bit lines up with the first discarded bit, and the rest follow downward.

Top module: `sr_narrow_fp16`

## Requirements
- R1: valid_out is valid_in delayed by one clock. Under reset, valid_out, res_out, ovf_out and inv_out read zero. The outputs hold their value in any cycle that follows a cycle with valid_in low.
- R2: With mode_in = 0, a finite in-range operand rounds to the nearest binary16 value. An exact halfway case goes to the neighbour whose mantissa LSB is 0.
- R3: With mode_in = 1, rnd_in is added to the 25-bit discard field, with rnd_in bit 24 under the first discarded bit. The magnitude is incremented by one unit in the last place exactly when that add carries out. A halfway operand therefore rounds up for rnd_in = 0x1000000 and down for 0x0FFFFFF.
- R4: With mode_in = 1, rnd_in of all zeros gives the truncated result. rnd_in of all ones gives the next magnitude up whenever any discarded bit is non-zero.
- R5: An operand whose discarded bits are all zero converts exactly in either mode and for any rnd_in. For example, 0x3F800000 gives 0x3C00.
- R6: A rounding carry out of the mantissa increments the exponent field. A carry from exponent 30 with mantissa 0x3FF gives signed infinity with ovf_out = 1, so 0x477FF000 in nearest mode gives 0x7C00. A carry out of a subnormal gives exponent field 1.
- R7: A finite operand with biased exponent 143 or more gives signed infinity (0x7C00 or 0xFC00) with ovf_out = 1.
- R8: An infinite operand gives the infinity of the same sign, with ovf_out = 0 and inv_out = 0.
- R9: A NaN operand gives exponent field 31 with mantissa {1, op_in[21:13]} and the same sign. inv_out = 1 exactly when op_in[22] = 0 (a signalling NaN).
- R10: Results below 2^-14 have exponent field 0 and are rounded as subnormals in units of 2^-24. An operand below 2^-26 counts as a non-zero value under a quarter unit. It gives zero in nearest mode, and in stochastic mode it gives the smallest subnormal only for rnd_in of all ones.
- R11: A zero operand gives a zero of the same sign with both flags clear.
- R12: In nearest mode, rnd_in has no effect on res_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Operand present this cycle |
| mode_in | input | 1 | 0 = nearest-even, 1 = stochastic |
| op_in | input | 32 | binary32 operand |
| rnd_in | input | RND_W (25) | Random word aligned to the discard field |
| valid_out | output | 1 | Result present |
| res_out | output | 16 | binary16 result |
| ovf_out | output | 1 | Finite operand became infinity |
| inv_out | output | 1 | Signalling NaN operand |

## Verification
The rounding increment and the exponent step it causes happen in the same cycle as the class decision. Two such collisions are driven on purpose. The first is the largest finite mantissa at exponent 30 with a halfway or random-driven discard field, where the carry has to turn into infinity and raise the overflow flag. The second is the top of the subnormal range with a discard field above half, where the carry has to produce the smallest normal encoding. For each of these, the bench model works out the expected word from scaled integer arithmetic on the operand's value, not from the bit fields. The result is compared on every clock, in both modes and with the two extreme random words as well as random ones.

// File: rtl/sr_cvt_pkg.sv
package sr_cvt_pkg;

    localparam int SRC_EW   = 8;
    localparam int SRC_MW   = 23;
    localparam int DST_EW   = 5;
    localparam int DST_MW   = 10;
    localparam int SRC_BIAS = 127;
    localparam int DST_BIAS = 15;
    localparam int SRC_W    = 1 + SRC_EW + SRC_MW;
    localparam int DST_W    = 1 + DST_EW + DST_MW;
    localparam int SIG_W    = SRC_MW + 1;
    localparam int DROP_W   = SRC_MW - DST_MW;

    // smallest source exponent that still maps to a normal destination value
    localparam logic [SRC_EW-1:0] NORM_MIN_E = SRC_EW'(SRC_BIAS - DST_BIAS + 1);
    // first source exponent whose destination exponent would be all ones
    localparam logic [SRC_EW-1:0] HUGE_MIN_E = SRC_EW'(SRC_BIAS - DST_BIAS + (1 << DST_EW) - 1);
    localparam logic [SRC_EW-1:0] SRC_EMAX   = '1;
    localparam logic [DST_EW-1:0] DST_EMAX   = '1;

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_TINY,
        CL_SUBN,
        CL_NORM,
        CL_HUGE,
        CL_INF,
        CL_NAN
    } opclass_t;

    typedef enum logic {
        RM_NEAREST = 1'b0,
        RM_STOCH   = 1'b1
    } rmode_t;

endpackage

// File: rtl/sr_cvt_classify.sv
module sr_cvt_classify
    import sr_cvt_pkg::*;
#(
    parameter int FRAC_EXT = 12,
    localparam int SH_W = $clog2(FRAC_EXT + 1)
) (
    input  logic [SRC_EW-1:0] exp_in,
    input  logic [SRC_MW-1:0] man_in,
    output opclass_t          cls,
    output logic [SH_W-1:0]   shamt,
    output logic [DST_EW-1:0] exp_dst
);

    localparam logic [SRC_EW-1:0] SUBN_MIN_E = NORM_MIN_E - SRC_EW'(FRAC_EXT);

    logic man_nz;
    logic [SRC_EW-1:0] sub_gap;

    assign man_nz  = |man_in;
    assign sub_gap = NORM_MIN_E - exp_in;

    always_comb begin
        shamt   = '0;
        exp_dst = DST_EW'(exp_in - (NORM_MIN_E - SRC_EW'(1)));
        if (exp_in == SRC_EMAX) begin
            cls = man_nz ? CL_NAN : CL_INF;
        end else if (exp_in >= HUGE_MIN_E) begin
            cls = CL_HUGE;
        end else if (exp_in >= NORM_MIN_E) begin
            cls = CL_NORM;
        end else if (exp_in == '0) begin
            cls = man_nz ? CL_TINY : CL_ZERO;
        end else if (exp_in >= SUBN_MIN_E) begin
            cls   = CL_SUBN;
            shamt = SH_W'(sub_gap);
        end else begin
            cls = CL_TINY;
        end
    end

endmodule

// File: rtl/sr_cvt_align.sv
module sr_cvt_align
    import sr_cvt_pkg::*;
#(
    parameter int FRAC_EXT = 12,
    localparam int SH_W  = $clog2(FRAC_EXT + 1),
    localparam int WIDE  = SIG_W + FRAC_EXT,
    localparam int DISC  = WIDE - (DST_MW + 1)
) (
    input  logic [SIG_W-1:0]  sig,
    input  logic [SH_W-1:0]   shamt,
    input  logic              tiny,
    output logic              hidden,
    output logic [DST_MW-1:0] kept,
    output logic [DISC-1:0]   disc
);

    logic [WIDE-1:0] wide;

    // frame is wide enough that a subnormal shift never loses a bit
    assign wide = {sig, {FRAC_EXT{1'b0}}} >> shamt;

    always_comb begin
        if (tiny) begin
            // far below the smallest subnormal: keep only "non-zero" as a jammed bit
            hidden = 1'b0;
            kept   = '0;
            disc   = DISC'(1);
        end else begin
            hidden = wide[WIDE-1];
            kept   = wide[WIDE-2 -: DST_MW];
            disc   = wide[DISC-1:0];
        end
    end

endmodule

// File: rtl/sr_cvt_round.sv
module sr_cvt_round
    import sr_cvt_pkg::*;
#(
    parameter int DISC = 25
) (
    input  rmode_t          mode,
    input  logic            lsb,
    input  logic [DISC-1:0] disc,
    input  logic [DISC-1:0] rnd,
    output logic            inc
);

    logic guard;
    logic rest;
    logic inc_near;
    logic inc_stoch;

    assign guard    = disc[DISC-1];
    assign rest     = |disc[DISC-2:0];
    assign inc_near = guard & (rest | lsb);
    // disc + rnd carries out exactly when disc exceeds the complement of rnd
    assign inc_stoch = (disc > ~rnd);

    always_comb begin
        unique case (mode)
            RM_NEAREST: inc = inc_near;
            RM_STOCH:   inc = inc_stoch;
            default:    inc = inc_near;
        endcase
    end

endmodule

// File: rtl/sr_narrow_fp16.sv
module sr_narrow_fp16
    import sr_cvt_pkg::*;
#(
    parameter int FRAC_EXT = 12,
    localparam int RND_W = DROP_W + FRAC_EXT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_in,
    input  logic             mode_in,
    input  logic [31:0]      op_in,
    input  logic [RND_W-1:0] rnd_in,
    output logic             valid_out,
    output logic [15:0]      res_out,
    output logic             ovf_out,
    output logic             inv_out
);

    localparam int SH_W = $clog2(FRAC_EXT + 1);
    localparam int MAG_W = DST_W - 1;

    logic               sgn;
    logic [SRC_EW-1:0]  exp_s;
    logic [SRC_MW-1:0]  man_s;
    opclass_t           cls;
    logic [SH_W-1:0]    shamt;
    logic [DST_EW-1:0]  exp_d;
    logic               hidden;
    logic [DST_MW-1:0]  kept;
    logic [RND_W-1:0]   disc;
    logic               inc;
    rmode_t             mode;
    logic [MAG_W-1:0]   rounded;
    logic [DST_W-1:0]   res_d;
    logic               ovf_d;
    logic               inv_d;

    assign sgn   = op_in[SRC_W-1];
    assign exp_s = op_in[SRC_W-2 -: SRC_EW];
    assign man_s = op_in[SRC_MW-1:0];
    assign mode  = rmode_t'(mode_in);

    sr_cvt_classify #(.FRAC_EXT(FRAC_EXT)) u_class (
        .exp_in  (exp_s),
        .man_in  (man_s),
        .cls     (cls),
        .shamt   (shamt),
        .exp_dst (exp_d)
    );

    sr_cvt_align #(.FRAC_EXT(FRAC_EXT)) u_align (
        .sig    ({1'b1, man_s}),
        .shamt  (shamt),
        .tiny   (cls == CL_TINY),
        .hidden (hidden),
        .kept   (kept),
        .disc   (disc)
    );

    sr_cvt_round #(.DISC(RND_W)) u_round (
        .mode (mode),
        .lsb  (kept[0]),
        .disc (disc),
        .rnd  (rnd_in),
        .inc  (inc)
    );

    // a mantissa carry ripples into the exponent field of the packed word
    assign rounded = {(hidden ? exp_d : {DST_EW{1'b0}}), kept} + MAG_W'(inc);

    always_comb begin
        res_d = '0;
        ovf_d = 1'b0;
        inv_d = 1'b0;
        unique case (cls)
            CL_ZERO: begin
                res_d = {sgn, {MAG_W{1'b0}}};
            end
            CL_TINY, CL_SUBN, CL_NORM: begin
                res_d = {sgn, rounded};
                ovf_d = (rounded[MAG_W-1 -: DST_EW] == DST_EMAX);
            end
            CL_HUGE: begin
                res_d = {sgn, DST_EMAX, {DST_MW{1'b0}}};
                ovf_d = 1'b1;
            end
            CL_INF: begin
                res_d = {sgn, DST_EMAX, {DST_MW{1'b0}}};
            end
            CL_NAN: begin
                res_d = {sgn, DST_EMAX, 1'b1, man_s[SRC_MW-2 -: DST_MW-1]};
                inv_d = ~man_s[SRC_MW-1];
            end
            default: begin
                res_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
            res_out   <= '0;
            ovf_out   <= 1'b0;
            inv_out   <= 1'b0;
        end else begin
            valid_out <= valid_in;
            if (valid_in) begin
                res_out <= res_d;
                ovf_out <= ovf_d;
                inv_out <= inv_d;
            end
        end
    end

endmodule

// File: rtl/sr_narrow_fp16_chk.sv
module sr_narrow_fp16_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        valid_in,
    input logic [31:0] op_in,
    input logic        valid_out,
    input logic [15:0] res_out,
    input logic        ovf_out,
    input logic        inv_out
);

    p_valid_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);

    p_valid_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out);

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(res_out));

    p_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && op_in[30:23] >= 8'd113 && op_in[30:23] <= 8'd142 && op_in[12:0] == 13'd0)
        |=> (res_out[9:0] == $past(op_in[22:13]) &&
             {3'b000, res_out[14:10]} == $past(op_in[30:23]) - 8'd112 && !ovf_out));

    p_ovf_is_inf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && ovf_out) |-> (res_out[14:0] == 15'h7C00 && !inv_out));

    p_huge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && op_in[30:23] >= 8'd143 && op_in[30:23] != 8'hFF)
        |=> (res_out[14:0] == 15'h7C00 && ovf_out));

    p_inf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && op_in[30:0] == 31'h7F800000)
        |=> (res_out[14:0] == 15'h7C00 && !ovf_out && !inv_out));

    p_nan_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && op_in[30:23] == 8'hFF && op_in[22:0] != 23'd0)
        |=> (res_out[14:9] == 6'b111111 && inv_out == !$past(op_in[22])));

    p_sign_r11: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> (res_out[15] == $past(op_in[31])));

    p_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && op_in[30:0] == 31'd0) |=> (res_out[14:0] == 15'd0 && !ovf_out));

endmodule

bind sr_narrow_fp16 sr_narrow_fp16_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_in  (valid_in),
    .op_in     (op_in),
    .valid_out (valid_out),
    .res_out   (res_out),
    .ovf_out   (ovf_out),
    .inv_out   (inv_out)
);

// File: tb/sim_sr_narrow_fp16.sv
module sim_sr_narrow_fp16;

    localparam int RW = 25;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid_in = 1'b0;
    logic          mode_in = 1'b0;
    logic [31:0]   op_in = '0;
    logic [RW-1:0] rnd_in = '0;
    logic          valid_out;
    logic [15:0]   res_out;
    logic          ovf_out;
    logic          inv_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [15:0] q_res[$];
    bit          q_ov[$];
    bit          q_iv[$];
    string       q_tag[$];
    bit          exp_vout = 0;

    always #2 clk = ~clk;

    sr_narrow_fp16 u0 (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .mode_in(mode_in),
        .op_in(op_in), .rnd_in(rnd_in), .valid_out(valid_out), .res_out(res_out),
        .ovf_out(ovf_out), .inv_out(inv_out)
    );

    // value-based reference: operand = sig * 2^(e-23), quantum 2^q
    function automatic void model(input logic [31:0] x, input bit m, input logic [RW-1:0] r,
                                  output logic [15:0] y, output bit ov, output bit iv);
        bit     s = x[31];
        int     ex = int'(x[30:23]);
        longint mn = longint'(x[22:0]);
        longint sig, fl, rem, half, rs, mm;
        int     e, q, k, ee;
        bit     inc;
        ov = 0; iv = 0;
        if (ex == 255) begin
            if (mn == 0) y = {s, 15'h7C00};
            else begin
                y  = {s, 5'h1F, 1'b1, x[21:13]};
                iv = !x[22];
            end
        end else if (ex == 0 && mn == 0) begin
            y = {s, 15'h0};
        end else begin
            sig = (ex == 0) ? mn : (mn + 64'h800000);
            e   = (ex == 0) ? -126 : ex - 127;
            q   = (e >= -14) ? e - 10 : -24;
            k   = q - (e - 23);
            if (k >= 40) begin fl = 0; rem = sig; end
            else begin fl = sig >> k; rem = sig - (fl << k); end
            if (!m) begin
                if (k >= 40) inc = 0;
                else begin
                    half = 64'd1 << (k - 1);
                    inc  = (rem > half) || (rem == half && fl[0]);
                end
            end else begin
                if (k <= 25) rs = rem << (25 - k);
                else rs = (rem != 0) ? 1 : 0;
                inc = (rs + longint'(r)) >= (64'd1 << 25);
            end
            mm = fl + (inc ? 1 : 0);
            if (mm >= 2048) begin mm = mm >> 1; q = q + 1; end
            if (mm >= 1024) begin ee = q + 25; mm = mm - 1024; end
            else ee = 0;
            if (ee >= 31) begin y = {s, 15'h7C00}; ov = 1; end
            else y = {s, ee[4:0], mm[9:0]};
        end
    endfunction

    task automatic check_cycle();
        logic [15:0] er;
        bit eo, ei;
        string t;
        total++;
        if (valid_out !== exp_vout) begin
            bad++;
            $display("FAIL R1 valid_out got %b exp %b", valid_out, exp_vout);
        end
        if (exp_vout && q_res.size() > 0) begin
            er = q_res.pop_front(); eo = q_ov.pop_front(); ei = q_iv.pop_front(); t = q_tag.pop_front();
            total++;
            if (res_out !== er || ovf_out !== eo || inv_out !== ei) begin
                bad++;
                $display("FAIL %s res/ovf/inv got %h/%b/%b exp %h/%b/%b", t, res_out, ovf_out, inv_out, er, eo, ei);
            end
        end
    endtask

    task automatic step(input bit v, input logic [31:0] x, input bit m, input logic [RW-1:0] r, input string tag);
        logic [15:0] y;
        bit ov, iv;
        @(negedge clk);
        check_cycle();
        valid_in = v; op_in = x; mode_in = m; rnd_in = r;
        if (v) begin
            model(x, m, r, y, ov, iv);
            q_res.push_back(y); q_ov.push_back(ov); q_iv.push_back(iv); q_tag.push_back(tag);
        end
        exp_vout = v;
    endtask

    // directed vector with an independently written expected word
    task automatic fixed(input logic [31:0] x, input bit m, input logic [RW-1:0] r,
                         input logic [15:0] want, input string tag);
        logic [15:0] y;
        bit ov, iv;
        model(x, m, r, y, ov, iv);
        total++;
        if (y !== want) begin
            bad++;
            $display("FAIL %s model self-check got %h exp %h", tag, y, want);
        end
        step(1, x, m, r, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if (valid_out !== 1'b0 || res_out !== 16'h0 || ovf_out !== 1'b0 || inv_out !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset state got %b/%h exp 0/0000", valid_out, res_out);
        end
        rst_n = 1'b1;

        fixed(32'h3F800000, 0, '0, 16'h3C00, "R5");
        fixed(32'h3F800000, 1, '1, 16'h3C00, "R5");
        fixed(32'h3F801000, 0, '0, 16'h3C00, "R2");
        fixed(32'h3F803000, 0, '0, 16'h3C02, "R2");
        fixed(32'h3F801000, 0, '1, 16'h3C00, "R12");
        fixed(32'h3F803000, 0, 25'h0AAAAAA, 16'h3C02, "R12");
        fixed(32'h3F801000, 1, '0, 16'h3C00, "R4");
        fixed(32'h3F801000, 1, '1, 16'h3C01, "R4");
        fixed(32'h3F800001, 1, '1, 16'h3C01, "R4");
        fixed(32'h3F801000, 1, 25'h1000000, 16'h3C01, "R3");
        fixed(32'h3F801000, 1, 25'h0FFFFFF, 16'h3C00, "R3");
        step(0, 32'h0, 0, '0, "R1");
        step(0, 32'hFFFFFFFF, 1, '1, "R1");
        fixed(32'h477FE000, 0, '0, 16'h7BFF, "R5");
        fixed(32'h477FF000, 0, '0, 16'h7C00, "R6");
        fixed(32'h477FF000, 1, '0, 16'h7BFF, "R6");
        fixed(32'hC77FF000, 1, '1, 16'hFC00, "R6");
        fixed(32'h387FF000, 0, '0, 16'h0400, "R6");
        fixed(32'h501502F9, 0, '0, 16'h7C00, "R7");
        fixed(32'hD01502F9, 1, '0, 16'hFC00, "R7");
        fixed(32'h7F800000, 0, '0, 16'h7C00, "R8");
        fixed(32'hFF800000, 1, '1, 16'hFC00, "R8");
        fixed(32'h7FC00000, 0, '0, 16'h7E00, "R9");
        fixed(32'hFF800001, 0, '0, 16'hFE00, "R9");
        fixed(32'h7FA00000, 1, '0, 16'h7F00, "R9");
        fixed(32'h33800000, 0, '0, 16'h0001, "R10");
        fixed(32'h38000000, 0, '0, 16'h0200, "R10");
        fixed(32'h33000000, 0, '0, 16'h0000, "R10");
        fixed(32'h00000001, 0, '0, 16'h0000, "R10");
        fixed(32'h00000001, 1, '1, 16'h0001, "R10");
        fixed(32'h80000001, 1, '0, 16'h8000, "R10");
        fixed(32'h80000000, 1, '1, 16'h8000, "R11");
        fixed(32'h00000000, 0, '0, 16'h0000, "R11");

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] x;
            bit m;
            x = $urandom;
            if (i % 4 != 3) x[30:23] = 8'(95 + $urandom_range(0, 52));
            m = $urandom_range(0, 1) == 1;
            step($urandom_range(0, 7) != 0, x, m, RW'($urandom), m ? "R3" : "R2");
        end
        step(0, 32'h0, 0, '0, "R1");
        step(0, 32'h0, 0, '0, "R1");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog expired got running exp finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule